// File: doc/BRIEF.md
# In-Order Completion Token Buffer

This block puts results back into arrival order when they come out of a recirculating lookup engine in any order. A producer takes a token before it starts a request. The token is the index of a result slot that it reserves. When the lookup finishes, the producer writes the result together with that token into the reserved slot. Writes may arrive in any order. A consumer drains results strictly in the order the tokens were handed out. A finished result therefore waits until every older request has also finished.

The buffer has three ports, each with valid/ready signalling: token issue, tagged result write and in-order result read. All three can fire in the same clock, so a new request can enter while an old one leaves and no cycle is lost. The number of outstanding tokens is capped at the depth of the buffer, and this also bounds how many requests can be in flight. The depth defaults to 16 slots, which gives a 4-bit token. The payload width is a parameter.

Top module: `inorder_cbuf`

## Requirements
- R1: After reset the buffer offers a token (`tok_valid`=1) with `tok_id`=0, and `rd_valid` is 0.
- R2: Each accepted token issue (`tok_valid` and `tok_ready` high at a clock edge) returns the next slot index in sequence. The index counts up by one and wraps from 15 back to 0.
- R3: When all 16 slots are reserved and no read fires in that cycle, `tok_valid` is 0 and a request with `tok_ready` high takes no token.
- R4: A write (`wr_valid` high; `wr_ready` is always 1) stores `wr_data` in the slot named by `wr_tok`. Writes to reserved slots may come in any order.
- R5: Read data leaves in token issue order. The n-th read returns the value written under the n-th token issued.
- R6: `rd_valid` is 1 only when the oldest reserved slot has been written. Filled slots that are younger than an unfilled oldest slot keep `rd_valid` at 0.
- R7: A token issue, a result write and a result read can all fire in the same clock cycle. Under a steady stream of all three, no token is refused.
- R8: When all slots are reserved and a read fires, `tok_valid` is 1 in that same cycle. The token issued then is the index of the slot being freed.
- R9: A write to the oldest slot does not raise `rd_valid` in the cycle the write is presented. `rd_valid` rises in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | output | 1 | A token is available |
| tok_ready | input | 1 | Producer takes the offered token |
| tok_id | output | TOK_W | Index of the offered token/slot |
| wr_valid | input | 1 | Result write present |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_tok | input | TOK_W | Token the result belongs to |
| wr_data | input | DATA_W | Result payload |
| rd_valid | output | 1 | Oldest result is ready |
| rd_ready | input | 1 | Consumer takes the oldest result |
| rd_data | output | DATA_W | Oldest result payload |

## Verification
The bench builds the buffer with DEPTH=16, which gives 4-bit tokens and the power-of-two pointer wrap. It uses a 12-bit payload so that a width other than the default is elaborated. At this depth the bench can fill every slot, and can wrap the token index across the 15-to-0 boundary more than once. It can also write a full buffer in reverse order, and reuse a freed slot in the same cycle it is freed. The closing phase runs issue, write and read together in every cycle for 40 cycles, so that any lost cycle shows up as a refused token or a missing read.

// File: rtl/inorder_cbuf_pkg.sv
package inorder_cbuf_pkg;

   typedef enum logic {
      WRAP_POW2 = 1'b0,
      WRAP_CMP  = 1'b1
   } wrap_e;

   function automatic wrap_e pick_wrap(input int depth);
      if ((depth & (depth - 1)) == 0) return WRAP_POW2;
      return WRAP_CMP;
   endfunction

endpackage

// File: rtl/inorder_cbuf_ptrs.sv
module inorder_cbuf_ptrs #(
   parameter int DEPTH = 16,
   localparam int TOK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_fire,
   input  logic             read_fire,
   output logic [TOK_W-1:0] wr_ptr,
   output logic [TOK_W-1:0] rd_ptr,
   output logic             full
);
   import inorder_cbuf_pkg::*;

   localparam wrap_e           WRAP = pick_wrap(DEPTH);
   localparam logic [TOK_W-1:0] LAST = TOK_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

   logic [TOK_W-1:0] wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;

   // the pointer wrap is picked by the depth
   generate
      if (WRAP == WRAP_POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (issue_fire) wr_ptr <= wr_nxt;
         if (read_fire)  rd_ptr <= rd_nxt;
         cnt_q <= cnt_q + CNT_W'(issue_fire) - CNT_W'(read_fire);
      end
   end

   assign full = (cnt_q == CAP);

endmodule

// File: rtl/inorder_cbuf_slots.sv
module inorder_cbuf_slots #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   localparam int TOK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [TOK_W-1:0]  set_idx,
   input  logic [DATA_W-1:0] set_data,
   input  logic              clr_en,
   input  logic [TOK_W-1:0]  head_idx,
   output logic              head_filled,
   output logic [DATA_W-1:0] head_data
);
   logic [DEPTH-1:0]  filled_vec;
   logic [DATA_W-1:0] data_arr [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic              hit_set;
         logic              hit_clr;
         logic              f_q;
         logic [DATA_W-1:0] d_q;

         assign hit_set = set_en && (set_idx == TOK_W'(i));
         assign hit_clr = clr_en && (head_idx == TOK_W'(i));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               f_q <= 1'b0;
            end else begin
               if (hit_clr) f_q <= 1'b0;
               if (hit_set) f_q <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (hit_set) d_q <= set_data;
         end

         assign filled_vec[i] = f_q;
         assign data_arr[i]   = d_q;
      end
   endgenerate

   // registered flags: a write made this cycle shows on the next one
   assign head_filled = filled_vec[head_idx];
   assign head_data   = data_arr[head_idx];

endmodule

// File: rtl/inorder_cbuf.sv
module inorder_cbuf #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   localparam int TOK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              tok_valid,
   input  logic              tok_ready,
   output logic [TOK_W-1:0]  tok_id,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [TOK_W-1:0]  wr_tok,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("inorder_cbuf: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("inorder_cbuf: DATA_W must be at least 1");
      end
   endgenerate

   logic             issue_fire, read_fire, write_fire, full;
   logic [TOK_W-1:0] wr_ptr, rd_ptr;

   assign read_fire  = rd_valid && rd_ready;
   // a slot freed by a read may be handed out again in the same cycle
   assign tok_valid  = !full || read_fire;
   assign issue_fire = tok_valid && tok_ready;
   assign wr_ready   = 1'b1;
   assign write_fire = wr_valid;
   assign tok_id     = wr_ptr;

   inorder_cbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_fire (issue_fire),
      .read_fire  (read_fire),
      .wr_ptr     (wr_ptr),
      .rd_ptr     (rd_ptr),
      .full       (full)
   );

   inorder_cbuf_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_slots (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_en      (write_fire),
      .set_idx     (wr_tok),
      .set_data    (wr_data),
      .clr_en      (read_fire),
      .head_idx    (rd_ptr),
      .head_filled (rd_valid),
      .head_data   (rd_data)
   );

endmodule

// File: rtl/inorder_cbuf_chk.sv
module inorder_cbuf_chk #(
   parameter int DEPTH = 16,
   localparam int TOK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tok_valid,
   input logic             tok_ready,
   input logic [TOK_W-1:0] tok_id,
   input logic             wr_valid,
   input logic [TOK_W-1:0] wr_tok,
   input logic             rd_valid,
   input logic             rd_ready
);
   localparam logic [TOK_W-1:0] LAST = TOK_W'(DEPTH - 1);

   logic [TOK_W-1:0] s_wr, s_rd;
   logic [CNT_W-1:0] s_cnt;
   logic [DEPTH-1:0] s_res, s_fil;
   logic             tf, rf;

   assign tf = tok_valid && tok_ready;
   assign rf = rd_valid && rd_ready;

   function automatic logic [TOK_W-1:0] step_ptr(input logic [TOK_W-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_wr  <= '0;
         s_rd  <= '0;
         s_cnt <= '0;
         s_res <= '0;
         s_fil <= '0;
      end else begin
         if (rf) begin
            s_res[s_rd] <= 1'b0;
            s_fil[s_rd] <= 1'b0;
            s_rd        <= step_ptr(s_rd);
         end
         if (tf) begin
            s_res[s_wr] <= 1'b1;
            s_wr        <= step_ptr(s_wr);
         end
         if (wr_valid) s_fil[wr_tok] <= 1'b1;
         s_cnt <= s_cnt + CNT_W'(tf) - CNT_W'(rf);
      end
   end

   AST_TOKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |-> (tok_id == s_wr)); // R2

   AST_OFFER_WHEN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (s_cnt < CNT_W'(DEPTH)) |-> tok_valid); // R2

   AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((s_cnt == CNT_W'(DEPTH)) && !rf) |-> !tok_valid); // R3

   AST_WRITE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (s_res[wr_tok] && !s_fil[wr_tok])); // R4

   AST_HEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == ((s_cnt != '0) && s_fil[s_rd])); // R6

   AST_FULL_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((s_cnt == CNT_W'(DEPTH)) && rf) |-> (tok_valid && tok_id == s_rd)); // R8

   AST_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && (s_cnt != '0) && wr_tok == s_rd && !rd_valid) |=> rd_valid); // R9

endmodule

bind inorder_cbuf inorder_cbuf_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tok_valid (tok_valid),
   .tok_ready (tok_ready),
   .tok_id    (tok_id),
   .wr_valid  (wr_valid),
   .wr_tok    (wr_tok),
   .rd_valid  (rd_valid),
   .rd_ready  (rd_ready)
);

// File: tb/inorder_cbuf_bench.sv
`timescale 1ns/1ps
module inorder_cbuf_bench;
   localparam int DEPTH  = 16;
   localparam int DATA_W = 12;
   localparam int TOK_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tok_valid, tok_ready = 1'b0;
   logic [TOK_W-1:0]  tok_id;
   logic              wr_valid = 1'b0, wr_ready;
   logic [TOK_W-1:0]  wr_tok = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_valid, rd_ready = 1'b0;
   logic [DATA_W-1:0] rd_data;

   int total = 0;
   int bad = 0;
   int reads = 0;
   int triples = 0;
   int refusals = 0;
   bit finished = 1'b0;

   logic [DATA_W-1:0] exp_q [$];
   logic [DATA_W-1:0] pend [DEPTH];
   logic [TOK_W-1:0]  next_tok = '0;
   int                seq = 0;
   logic [TOK_W-1:0]  last_tok;
   bit                last_ok;

   always #5 clk = ~clk;

   inorder_cbuf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_inorder_cbuf (
      .clk(clk), .rst_n(rst_n),
      .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_id(tok_id),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tok(wr_tok), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: inputs change 1 ns after a rising edge, results are sampled at the falling edge
   task automatic step(input bit iss, input bit wv, input logic [TOK_W-1:0] wt, input bit rr);
      @(posedge clk);
      #1;
      tok_ready = iss;
      wr_valid  = wv;
      wr_tok    = wt;
      wr_data   = pend[wt];
      rd_ready  = rr;
      @(negedge clk);
      chk(wr_ready == 1'b1, "R4 wr_ready", int'(wr_ready), 1);
      last_ok = 1'b0;
      if (iss && tok_valid) begin
         chk(tok_id == next_tok, "R2 token index", int'(tok_id), int'(next_tok));
         pend[tok_id] = DATA_W'(12'h5A3 ^ (seq * 37));
         exp_q.push_back(pend[tok_id]);
         last_tok = tok_id;
         last_ok  = 1'b1;
         seq++;
         next_tok = next_tok + 1'b1;
      end
      if (iss && tok_valid && wv && rd_valid && rr) triples++;
   endtask

   // monitor: every read is compared with the oldest expected item
   always @(negedge clk) begin
      if (rst_n && rd_valid && rd_ready) begin
         reads++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected read", int'(rd_data), -1);
         end else begin
            chk(rd_data == exp_q[0], "R5 read order", int'(rd_data), int'(exp_q[0]));
            void'(exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) pend[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(tok_valid == 1'b1, "R1 tok_valid", int'(tok_valid), 1);
      chk(tok_id == '0, "R1 tok_id", int'(tok_id), 0);
      chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);

      // fill every slot
      for (int i = 0; i < DEPTH; i++) begin
         step(1, 0, '0, 0);
         chk(last_ok, "R2 issue accepted", int'(last_ok), 1);
      end
      step(1, 0, '0, 0);
      chk(tok_valid == 1'b0, "R3 refused when full", int'(tok_valid), 0);
      chk(!last_ok, "R3 no token taken", int'(last_ok), 0);

      // write results youngest first
      for (int t = DEPTH - 1; t >= 1; t--) step(0, 1, TOK_W'(t), 0);
      step(0, 0, '0, 1);
      chk(rd_valid == 1'b0, "R6 head empty", int'(rd_valid), 0);
      step(0, 1, '0, 1);
      chk(rd_valid == 1'b0, "R9 no same-cycle pass", int'(rd_valid), 0);

      // full and reading: a token is offered for the freed slot
      step(1, 0, '0, 1);
      chk(rd_valid == 1'b1, "R9 visible next cycle", int'(rd_valid), 1);
      chk(tok_valid == 1'b1, "R8 offer on free", int'(tok_valid), 1);
      chk(last_ok && last_tok == '0, "R8 freed slot reused", int'(last_tok), 0);

      for (int i = 0; i < DEPTH - 1; i++) step(0, 0, '0, 1);
      step(0, 0, '0, 1);
      chk(rd_valid == 1'b0, "R6 reissued slot not filled", int'(rd_valid), 0);
      step(0, 1, '0, 1);
      step(0, 0, '0, 1);
      step(0, 0, '0, 1);
      chk(reads == DEPTH + 1, "R5 read count", reads, DEPTH + 1);

      // small out-of-order group: tokens 1..4 written 3,1,4,2
      for (int i = 0; i < 4; i++) step(1, 0, '0, 1);
      step(0, 1, TOK_W'(3), 1);
      step(0, 1, TOK_W'(1), 1);
      chk(rd_valid == 1'b0, "R6 younger filled only", int'(rd_valid), 0);
      step(0, 1, TOK_W'(4), 1);
      chk(rd_valid == 1'b1, "R4 slot 1 filled", int'(rd_valid), 1);
      step(0, 1, TOK_W'(2), 1);
      for (int i = 0; i < 5; i++) step(0, 0, '0, 1);
      chk(reads == DEPTH + 5, "R5 group drained", reads, DEPTH + 5);
      chk(exp_q.size() == 0, "R5 queue empty", exp_q.size(), 0);

      // issue, write and read in every cycle
      begin
         bit               have_prev = 1'b0;
         logic [TOK_W-1:0] prev = '0;
         for (int k = 0; k < 40; k++) begin
            step(1, have_prev, prev, 1);
            if (!last_ok) refusals++;
            prev = last_tok;
            have_prev = last_ok;
         end
         step(0, have_prev, prev, 1);
      end
      for (int i = 0; i < 4; i++) step(0, 0, '0, 1);
      chk(refusals == 0, "R7 no refused token", refusals, 0);
      chk(triples >= 30, "R7 three ports together", triples, 30);
      chk(reads == DEPTH + 45, "R7 all streamed reads", reads, DEPTH + 45);
      chk(exp_q.size() == 0, "R5 stream queue empty", exp_q.size(), 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule